// File: doc/BRIEF.md
# SPI EEPROM Pin-Access Arbiter

This block is a 32-bit control and status word that decides who drives the three output pins of an SPI EEPROM: an automatic access engine or software that toggles the pins by hand. Software sets a request bit. The block answers with a grant once the engine reports that it is idle. While the grant is held, the clock, select and data-out bits that software writes appear on the pins, and the data-in pin can be read back in the same word. If software leaves the pins untouched for a configurable number of cycles, the block drops the request and the grant by itself. The pins then return to the engine.

The same word also carries two other functions. It reports whether an EEPROM is fitted and a 4-bit size code, both taken from static inputs. It also holds a flash-update trigger. A started update shows as busy for a configurable number of cycles and then raises a done flag. The word is written through a one-cycle write strobe with full 32-bit data, and it can be read at all times.

Top module: `spi_pin_arbiter`

## Requirements
- R1: Bit 8 of the read word equals `ee_present` and bits 14:11 equal `ee_size_code` (code 7 = 16 KB part, code 8 = 32 KB part).
- R2: Bit 3 of the read word shows the level of `spi_so`, registered once, so it follows the pin one clock edge later.
- R3: A write sets or clears the request bit (bit 6) to the value of wr_data[6]. The grant bit (bit 7) is never 1 while the request bit is 0, and it falls on the same edge as the request bit.
- R4: The grant rises only on an edge where `eng_busy` is low. Once granted, it stays set even if `eng_busy` later goes high.
- R5: While the grant is 0, `spi_sck`/`spi_cs`/`spi_si` equal `eng_sck`/`eng_cs`/`eng_si` delayed by one edge. The software pin bits then have no effect on the pins.
- R6: While the grant is 1, the pins take the software bits SCK (bit 0), CS (bit 1) and SI (bit 2) on the same edge that the write stores them.
- R7: While granted, if no write changes bits 2:0 for TIMEOUT_CYC consecutive edges after the grant edge or after the last change, request and grant both clear on that edge. A write that changes any of bits 2:0 restarts the count.
- R8: Writing 1 to bit 23 while no update is running starts an update. Bit 23 then reads 1 for FLUPD_CYC edges. On the FLUPD_CYC-th edge, bit 23 falls and bit 26 (done) rises.
- R9: Starting an update clears bit 26 on the start edge.
- R10: After reset the read word has SCK=0, CS=1, SI=0, request 0, grant 0, bit 23 = 0 and bit 26 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control/status word |
| ee_present | input | 1 | EEPROM fitted indication |
| ee_size_code | input | 4 | EEPROM size code |
| eng_busy | input | 1 | Automatic engine is running |
| eng_sck | input | 1 | Engine SPI clock |
| eng_cs | input | 1 | Engine SPI select |
| eng_si | input | 1 | Engine SPI data toward EEPROM |
| spi_sck | output | 1 | SPI clock pin |
| spi_cs | output | 1 | SPI select pin |
| spi_si | output | 1 | SPI data pin toward EEPROM |
| spi_so | input | 1 | SPI data pin from EEPROM |

## Verification
The hardest case to reach is the inactivity revocation. The count must expire exactly TIMEOUT_CYC edges after the last pin change, and a pin change part way through must restart it. The bench shortens the timeout through the parameter and grants access. It checks the grant one edge before expiry and again on the expiry edge, then repeats the check after a mid-window write that changes a pin. A grant request made while the engine is busy, and an engine that turns busy after the grant, are driven from the vector table so that both sides of R4 are seen.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  localparam int B_SCK   = 0;
  localparam int B_CS    = 1;
  localparam int B_SI    = 2;
  localparam int B_SO    = 3;
  localparam int B_REQ   = 6;
  localparam int B_GNT   = 7;
  localparam int B_PRES  = 8;
  localparam int B_SIZE  = 11;
  localparam int W_SIZE  = 4;
  localparam int B_FLGO  = 23;
  localparam int B_FLDN  = 26;

  typedef struct packed {
    logic si;
    logic cs;
    logic sck;
  } pins_t;

  localparam pins_t PINS_RST = '{si: 1'b0, cs: 1'b1, sck: 1'b0};
endpackage

// File: rtl/arb_pinmux.sv
module arb_pinmux
  import spi_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  pins_t wr_pins,
  input  logic  gnt_nx,
  input  pins_t eng_pins,
  output pins_t sw_pins,
  output pins_t pin_out,
  output logic  pin_chg
);
  pins_t sw_nx;

  assign pin_chg = wr_en && (wr_pins != sw_pins);
  assign sw_nx   = wr_en ? wr_pins : sw_pins;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_pins <= PINS_RST;
      pin_out <= PINS_RST;
    end else begin
      sw_pins <= sw_nx;
      pin_out <= gnt_nx ? sw_nx : eng_pins;
    end
  end
endmodule

// File: rtl/arb_grant.sv
module arb_grant #(
  parameter int TIMEOUT_CYC = 200_000_000,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_req,
  input  logic pin_chg,
  input  logic eng_busy,
  output logic req_q,
  output logic gnt_q,
  output logic gnt_nx
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] idle_cnt;
  logic          expire;
  logic          req_nx;

  assign expire = gnt_q && !pin_chg && (idle_cnt == LAST);
  assign req_nx = expire ? 1'b0 : (wr_en ? wr_req : req_q);
  assign gnt_nx = req_nx && (gnt_q || !eng_busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      gnt_q    <= 1'b0;
      idle_cnt <= '0;
    end else begin
      req_q <= req_nx;
      gnt_q <= gnt_nx;
      if (!gnt_q || pin_chg) idle_cnt <= '0;
      else if (!expire)      idle_cnt <= idle_cnt + 1'b1;
      else                   idle_cnt <= '0;
    end
  end

  a_r3_gnt_needs_req: assert property (@(posedge clk) disable iff (rst)
    gnt_q |-> req_q);
  a_r4_gnt_when_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_q) |-> $past(!eng_busy));
  a_r7_timeout_drops: assert property (@(posedge clk) disable iff (rst)
    (gnt_q && !pin_chg && idle_cnt == LAST) |=> (!req_q && !gnt_q));
endmodule

// File: rtl/arb_flupd.sv
module arb_flupd #(
  parameter int FLUPD_CYC = 1000,
  localparam int CW = $clog2(FLUPD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_q,
  output logic done_q
);
  localparam logic [CW-1:0] LAST = CW'(FLUPD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt    <= '0;
      end
    end else if (cnt == LAST) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r8_done_excl_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy_q));
  a_r9_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !done_q);
endmodule

// File: rtl/spi_pin_arbiter.sv
module spi_pin_arbiter
  import spi_arb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200_000_000,
  parameter int FLUPD_CYC   = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        ee_present,
  input  logic [3:0]  ee_size_code,
  input  logic        eng_busy,
  input  logic        eng_sck,
  input  logic        eng_cs,
  input  logic        eng_si,
  output logic        spi_sck,
  output logic        spi_cs,
  output logic        spi_si,
  input  logic        spi_so
);
  pins_t wr_pins, eng_pins, sw_pins, pin_out;
  logic  pin_chg, req_q, gnt_q, gnt_nx, so_q, fl_busy, fl_done;

  assign wr_pins  = '{si: wr_data[B_SI], cs: wr_data[B_CS], sck: wr_data[B_SCK]};
  assign eng_pins = '{si: eng_si, cs: eng_cs, sck: eng_sck};

  arb_pinmux u_mux (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pins(wr_pins),
    .gnt_nx(gnt_nx), .eng_pins(eng_pins), .sw_pins(sw_pins),
    .pin_out(pin_out), .pin_chg(pin_chg)
  );

  arb_grant #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_gnt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_req(wr_data[B_REQ]),
    .pin_chg(pin_chg), .eng_busy(eng_busy),
    .req_q(req_q), .gnt_q(gnt_q), .gnt_nx(gnt_nx)
  );

  arb_flupd #(.FLUPD_CYC(FLUPD_CYC)) u_upd (
    .clk(clk), .rst(rst), .start(wr_en && wr_data[B_FLGO]),
    .busy_q(fl_busy), .done_q(fl_done)
  );

  always_ff @(posedge clk) begin
    if (rst) so_q <= 1'b0;
    else     so_q <= spi_so;
  end

  assign spi_sck = pin_out.sck;
  assign spi_cs  = pin_out.cs;
  assign spi_si  = pin_out.si;

  always_comb begin
    rd_data                       = '0;
    rd_data[B_SCK]                = sw_pins.sck;
    rd_data[B_CS]                 = sw_pins.cs;
    rd_data[B_SI]                 = sw_pins.si;
    rd_data[B_SO]                 = so_q;
    rd_data[B_REQ]                = req_q;
    rd_data[B_GNT]                = gnt_q;
    rd_data[B_PRES]               = ee_present;
    rd_data[B_SIZE +: W_SIZE]     = ee_size_code;
    rd_data[B_FLGO]               = fl_busy;
    rd_data[B_FLDN]               = fl_done;
  end

  // R5: with no grant, the pins carry the engine levels of the previous edge
  a_r5_engine_owns_pins: assert property (@(posedge clk) disable iff (rst)
    (!gnt_q && $past(!rst)) |->
      (spi_sck == $past(eng_sck) && spi_cs == $past(eng_cs) && spi_si == $past(eng_si)));
  a_r6_sw_owns_pins: assert property (@(posedge clk) disable iff (rst)
    gnt_q |-> (pin_out == sw_pins));
endmodule

// File: tb/tb_spi_pin_arbiter.sv
module tb_spi_pin_arbiter;
  localparam int TO = 50;
  localparam int FU = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ee_present = 1'b1;
  logic [3:0]  ee_size_code = 4'd8;
  logic        eng_busy = 1'b0;
  logic        eng_sck = 1'b1, eng_cs = 1'b0, eng_si = 1'b1;
  logic        spi_sck, spi_cs, spi_si;
  logic        spi_so = 1'b0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  spi_pin_arbiter #(.TIMEOUT_CYC(TO), .FLUPD_CYC(FU)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ee_present(ee_present), .ee_size_code(ee_size_code), .eng_busy(eng_busy),
    .eng_sck(eng_sck), .eng_cs(eng_cs), .eng_si(eng_si),
    .spi_sck(spi_sck), .spi_cs(spi_cs), .spi_si(spi_si), .spi_so(spi_so)
  );

  // {write data, eng_busy, expected pins {si,cs,sck}, expected grant}
  localparam logic [36:0] VEC [0:7] = '{
    {32'h0000_0042, 1'b1, 3'b101, 1'b0},
    {32'h0000_0042, 1'b0, 3'b010, 1'b1},
    {32'h0000_0043, 1'b0, 3'b011, 1'b1},
    {32'h0000_0044, 1'b0, 3'b100, 1'b1},
    {32'h0000_0044, 1'b1, 3'b100, 1'b1},
    {32'h0000_0002, 1'b0, 3'b101, 1'b0},
    {32'h0000_0047, 1'b0, 3'b111, 1'b1},
    {32'h0000_0000, 1'b0, 3'b101, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R10 reset word, R1 presence/size (pres bit8, size 8 at 14:11)
    check("R10 reset word", rd_data, 32'h0000_4102);
    check("R1 size/pres", {27'd0, rd_data[8], rd_data[14:11]}, {27'd0, 1'b1, 4'd8});
    // R5 engine drives pins without grant
    check("R5 idle pins", {29'd0, spi_si, spi_cs, spi_sck}, 32'd5);
    // R2 SO readback
    spi_so = 1'b1; step(1);
    check("R2 so high", {31'd0, rd_data[3]}, 32'd1);
    spi_so = 1'b0; step(1);
    check("R2 so low", {31'd0, rd_data[3]}, 32'd0);

    // R3 R4 R5 R6 via vector table
    for (int v = 0; v < 8; v++) begin
      eng_busy = VEC[v][4];
      wr(VEC[v][36:5]);
      check("R4/R3 grant vec", {31'd0, rd_data[7]}, {31'd0, VEC[v][0]});
      check("R5/R6 pins vec", {29'd0, spi_si, spi_cs, spi_sck}, {29'd0, VEC[v][3:1]});
      check("R3 req vec", {31'd0, rd_data[6]}, {31'd0, VEC[v][5 + 6]});
    end
    eng_busy = 1'b0;

    // R7 timeout from grant edge
    wr(32'h0000_0042);
    check("R7 granted", {31'd0, rd_data[7]}, 32'd1);
    step(TO - 1);
    check("R7 before expiry", {30'd0, rd_data[7:6]}, 32'd3);
    step(1);
    check("R7 expired", {30'd0, rd_data[7:6]}, 32'd0);
    check("R7 pins back to engine", {29'd0, spi_si, spi_cs, spi_sck}, 32'd5);

    // R7 restart by pin change
    wr(32'h0000_0042);
    step(30);
    wr(32'h0000_0043);
    step(TO - 1);
    check("R7 restarted still granted", {31'd0, rd_data[7]}, 32'd1);
    step(1);
    check("R7 restarted expiry", {31'd0, rd_data[7]}, 32'd0);

    // R8 flash update
    wr(32'h0080_0000);
    check("R8 busy on start", {30'd0, rd_data[26], rd_data[23]}, 32'd1);
    step(FU - 1);
    check("R8 busy before end", {30'd0, rd_data[26], rd_data[23]}, 32'd1);
    step(1);
    check("R8 done", {30'd0, rd_data[26], rd_data[23]}, 32'd2);
    // R9 restart clears done
    wr(32'h0080_0000);
    check("R9 done cleared", {30'd0, rd_data[26], rd_data[23]}, 32'd1);
    step(FU + 2);
    check("R8 done again", {30'd0, rd_data[26], rd_data[23]}, 32'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule